// File: doc/BRIEF.md
# Frame Fetch and Palette Sequencer

This block runs the per-frame set-up work of a display controller. When the controller is switched on, and again on every frame tick, it reads a 256-word palette from the start of the active frame buffer. It does this over a single-outstanding word-read port, and stores the words in an on-chip palette RAM that the pixel unpacker reads. The first palette word also serves as a header. Bits 14:12 of that word give the pixel depth, and the depth decides how far into the buffer the pixel data begins.

For each frame the sequencer does the following:
- It computes the pixel-data base address, the line stride and the line window, taking the subpanel setting into account.
- It checks that the frame fits inside the programmed buffer bounds.
- If the frame fits, it raises a frame-start pulse with those values held on its outputs.
- If the frame does not fit, it flags a sync error and asks the register block to clear the enable.

In dual-buffer mode the buffer index alternates after each frame that is drawn. A load-mode input chooses between three behaviours: fetch the palette and draw, fetch the palette only, or draw using the palette already held.

Top module: `frame_seq`

## Requirements
- R1: Unless load_mode is 2, the block reads 256 16-bit words at byte addresses top+2*i of the active buffer. It does so once after enable rises and again on each accepted frame tick. Word i is stored at palette entry i, and pal_rdata returns the entry addressed by pal_raddr one clock later.
- R2: The depth code is bits 14:12 of palette entry 0. Code 1 gives pix_bpp 2, code 2 gives 4, code 3 gives 8, and codes 4 to 7 give 16. Code 0 is unsupported: the frame is skipped, with no frame_go, no dma_cond change and no buffer toggle.
- R3: pix_base is the active buffer top plus a skip. With the palette in use (load_mode not 2), the skip is 512 bytes for codes 3 to 7 and 32 bytes for codes 1 and 2. In load_mode 2 the skip is 0.
- R4: A frame overflows when skip + width*height*bpp/8 is greater than (bottom - top) + 2 of the active buffer. On overflow, sync_error is set and disable_req pulses, frame_go does not pulse, and later ticks are ignored until enable falls.
- R5: On each frame drawn, dma_cond bit cur_buf is set (bit 0 for buffer 0, bit 1 for buffer 1). With dual_buf high the buffer index then toggles; otherwise it stays 0.
- R6: If bufs_valid is low when enable rises, no read is issued, dma_cond bit 2 is set and disable_req pulses. dma_err_irq pulses only if dma_err_ie is high.
- R7: When sub_on is high, sub_line sets the line window. With sub_first high, sub_line is first_line and line_count is the full height. With sub_first low, first_line is 0 and line_count is sub_line. When sub_on is low, first_line is 0 and line_count is the height.
- R8: The width is width_m1+1 and the height is height_m1+1. line_stride equals width*bpp/8 bytes.
- R9: pal_loaded goes high when the first palette fetch of an enable period completes. It stays high until the next enable rise, and it never rises in load_mode 2.
- R10: While enable is low, the block issues no reads and no frame_go. In load_mode 1 the palette is still fetched at enable, but frame ticks are ignored.
- R11: rd_req stays high with rd_addr unchanged until rd_ready accepts it. Only one read is outstanding at a time, and its data returns with rsp_valid.
- R12: After reset, and at every enable rise, sync_error, pal_loaded and dma_cond are clear, and the buffer index restarts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Controller enable from the register block |
| load_mode | input | 2 | 0/3 palette and draw, 1 palette only, 2 draw only |
| dual_buf | input | 1 | Alternate between two frame buffers |
| dma_err_ie | input | 1 | Enable for the buffer-address error interrupt |
| bufs_valid | input | 1 | All buffer bound addresses are valid |
| width_m1 | input | DIM_W | Pixels per line minus one |
| height_m1 | input | DIM_W | Lines per frame minus one |
| sub_on | input | 1 | Subpanel window active |
| sub_first | input | 1 | Subpanel line is the first line (else the line count) |
| sub_line | input | DIM_W | Subpanel line number |
| top0 | input | ADDR_W | Buffer 0 start byte address |
| bot0 | input | ADDR_W | Buffer 0 end byte address |
| top1 | input | ADDR_W | Buffer 1 start byte address |
| bot1 | input | ADDR_W | Buffer 1 end byte address |
| frame_tick | input | 1 | Start-of-frame request |
| rd_req | output | 1 | Read request valid |
| rd_addr | output | ADDR_W | Read byte address |
| rd_ready | input | 1 | Read request accepted |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | 16 | Read data word |
| pal_raddr | input | PAL_AW | Palette read index |
| pal_rdata | output | 16 | Palette entry, one cycle after pal_raddr |
| frame_go | output | 1 | One-cycle frame-start pulse |
| cur_buf | output | 1 | Buffer index of the current frame |
| pix_base | output | ADDR_W | Byte address of the first pixel |
| pix_bpp | output | 5 | Bits per pixel |
| line_stride | output | DIM_W+3 | Bytes per line |
| first_line | output | DIM_W | First line drawn |
| line_count | output | DIM_W+1 | Lines drawn |
| dma_cond | output | 3 | Sticky: frame from buffer 0, frame from buffer 1, address error |
| dma_err_irq | output | 1 | One-cycle address-error interrupt pulse |
| sync_error | output | 1 | Frame overflowed its buffer |
| disable_req | output | 1 | One-cycle request to clear enable |
| pal_loaded | output | 1 | Palette loaded in this enable period |

## Verification
The assertions assume four things about the environment:
- load_mode, dual_buf and the buffer bounds change only while enable is low.
- Once a read has been accepted, its response arrives exactly once, and only after acceptance.
- The register block answers disable_req by lowering enable.
- enable does not rise again while a response to an aborted read is still pending.

The stimulus keeps to these rules. It reprograms the configuration only between enable periods, with idle cycles on both sides. The memory model answers each accepted read on the following clock with random ready back-pressure. The bench lowers enable itself after each disable request. Random cases choose buffer bottoms within a few bytes of the required size, so the overflow boundary is crossed in both directions.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_CHECK,
    ST_FETCH,
    ST_IDLE,
    ST_EVAL,
    ST_DECIDE,
    ST_HALT
  } seq_state_t;

  // bit position of the depth code inside the header word
  localparam int DEPTH_LSB = 12;

  // depth code to bits per pixel; 0 marks an unsupported code
  function automatic logic [4:0] depth_bits(input logic [2:0] code);
    case (code)
      3'd0:    return 5'd0;
      3'd1:    return 5'd2;
      3'd2:    return 5'd4;
      3'd3:    return 5'd8;
      default: return 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/pal_ram.sv
module pal_ram #(
  parameter int DEPTH = 256,
  parameter int W     = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  // simple dual-port, registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/pal_fetch.sv
module pal_fetch #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 256,
  parameter int W      = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int STEP  = W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              abort,
  input  logic [ADDR_W-1:0] base,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ready,
  input  logic              rsp_valid,
  input  logic [W-1:0]      rsp_data,
  output logic              we,
  output logic [AW-1:0]     waddr,
  output logic [W-1:0]      wdata,
  output logic [W-1:0]      hdr,
  output logic              done
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic          busy;
  logic          waiting;
  logic [AW-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      waiting <= 1'b0;
      rd_req  <= 1'b0;
      rd_addr <= '0;
      idx     <= '0;
      we      <= 1'b0;
      waddr   <= '0;
      wdata   <= '0;
      hdr     <= '0;
      done    <= 1'b0;
    end else begin
      we   <= 1'b0;
      done <= 1'b0;
      if (abort) begin
        busy    <= 1'b0;
        waiting <= 1'b0;
        rd_req  <= 1'b0;
      end else if (start) begin
        busy    <= 1'b1;
        waiting <= 1'b0;
        idx     <= '0;
        rd_req  <= 1'b1;
        rd_addr <= base;
      end else if (busy) begin
        if (rd_req && rd_ready) begin
          rd_req  <= 1'b0;
          waiting <= 1'b1;
        end
        if (waiting && rsp_valid) begin
          waiting <= 1'b0;
          we      <= 1'b1;
          waddr   <= idx;
          wdata   <= rsp_data;
          if (idx == '0) hdr <= rsp_data;
          if (idx == LAST) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            idx     <= idx + 1'b1;
            rd_req  <= 1'b1;
            rd_addr <= rd_addr + ADDR_W'(STEP);
          end
        end
      end
    end
  end

endmodule

// File: rtl/frame_geom.sv
module frame_geom #(
  parameter int ADDR_W     = 32,
  parameter int DIM_W      = 10,
  parameter int LONG_SKIP  = 512,
  parameter int SHORT_SKIP = 32,
  localparam int SZ_W      = 2 * (DIM_W + 1) + 5,
  localparam int CMP_W     = (ADDR_W > SZ_W ? ADDR_W : SZ_W) + 2,
  localparam int ST_W      = DIM_W + 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              calc,
  input  logic [2:0]        code,
  input  logic              use_pal,
  input  logic [DIM_W-1:0]  width_m1,
  input  logic [DIM_W-1:0]  height_m1,
  input  logic              sub_on,
  input  logic              sub_first,
  input  logic [DIM_W-1:0]  sub_line,
  input  logic [ADDR_W-1:0] top,
  input  logic [ADDR_W-1:0] bot,
  output logic [4:0]        g_bpp,
  output logic [ADDR_W-1:0] g_base,
  output logic [DIM_W+2:0]  g_stride,
  output logic [DIM_W-1:0]  g_first,
  output logic [DIM_W:0]    g_count,
  output logic              g_over,
  output logic              g_unsup
);

  import frame_seq_pkg::*;

  logic [4:0]        bpp;
  logic [DIM_W:0]    w_px, h_px;
  logic [ADDR_W-1:0] skip;
  logic [SZ_W-1:0]   bits_total;
  logic [CMP_W-1:0]  need, reach, limit;
  logic [ST_W-1:0]   line_bits;

  always_comb begin
    bpp        = depth_bits(code);
    w_px       = (DIM_W+1)'(width_m1) + (DIM_W+1)'(1);
    h_px       = (DIM_W+1)'(height_m1) + (DIM_W+1)'(1);
    if (!use_pal)       skip = '0;
    else if (code >= 3) skip = ADDR_W'(LONG_SKIP);
    else                skip = ADDR_W'(SHORT_SKIP);
    bits_total = SZ_W'(w_px) * SZ_W'(h_px) * SZ_W'(bpp);
    need       = CMP_W'(skip) + CMP_W'(bits_total >> 3);
    reach      = CMP_W'(top) + need;
    limit      = CMP_W'(bot) + CMP_W'(2);
    line_bits  = ST_W'(w_px) * ST_W'(bpp);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      g_bpp    <= '0;
      g_base   <= '0;
      g_stride <= '0;
      g_first  <= '0;
      g_count  <= '0;
      g_over   <= 1'b0;
      g_unsup  <= 1'b1;
    end else if (calc) begin
      g_bpp    <= bpp;
      g_base   <= top + skip;
      g_stride <= line_bits[ST_W-1:3];
      g_first  <= (sub_on && sub_first) ? sub_line : '0;
      g_count  <= (sub_on && !sub_first) ? (DIM_W+1)'(sub_line) : h_px;
      g_over   <= reach > limit;
      g_unsup  <= (bpp == 5'd0);
    end
  end

endmodule

// File: rtl/frame_seq.sv
module frame_seq #(
  parameter int ADDR_W     = 32,
  parameter int DIM_W      = 10,
  parameter int PAL_DEPTH  = 256,
  parameter int SHORT_SKIP = 32,
  localparam int PAL_W     = 16,
  localparam int PAL_AW    = $clog2(PAL_DEPTH),
  localparam int PAL_BYTES = PAL_DEPTH * PAL_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [1:0]        load_mode,
  input  logic              dual_buf,
  input  logic              dma_err_ie,
  input  logic              bufs_valid,
  input  logic [DIM_W-1:0]  width_m1,
  input  logic [DIM_W-1:0]  height_m1,
  input  logic              sub_on,
  input  logic              sub_first,
  input  logic [DIM_W-1:0]  sub_line,
  input  logic [ADDR_W-1:0] top0,
  input  logic [ADDR_W-1:0] bot0,
  input  logic [ADDR_W-1:0] top1,
  input  logic [ADDR_W-1:0] bot1,
  input  logic              frame_tick,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ready,
  input  logic              rsp_valid,
  input  logic [PAL_W-1:0]  rsp_data,
  input  logic [PAL_AW-1:0] pal_raddr,
  output logic [PAL_W-1:0]  pal_rdata,
  output logic              frame_go,
  output logic              cur_buf,
  output logic [ADDR_W-1:0] pix_base,
  output logic [4:0]        pix_bpp,
  output logic [DIM_W+2:0]  line_stride,
  output logic [DIM_W-1:0]  first_line,
  output logic [DIM_W:0]    line_count,
  output logic [2:0]        dma_cond,
  output logic              dma_err_irq,
  output logic              sync_error,
  output logic              disable_req,
  output logic              pal_loaded
);

  import frame_seq_pkg::*;

  seq_state_t        state;
  logic              buf_idx;
  logic              for_frame;
  logic              fetch_start;
  logic [ADDR_W-1:0] fetch_base;
  logic              calc;
  logic              use_pal;
  logic [ADDR_W-1:0] act_top, act_bot;

  logic              pr_we;
  logic [PAL_AW-1:0] pr_waddr;
  logic [PAL_W-1:0]  pr_wdata;
  logic [PAL_W-1:0]  hdr;
  logic              fetch_done;

  logic [4:0]        g_bpp;
  logic [ADDR_W-1:0] g_base;
  logic [DIM_W+2:0]  g_stride;
  logic [DIM_W-1:0]  g_first;
  logic [DIM_W:0]    g_count;
  logic              g_over, g_unsup;

  assign use_pal = (load_mode != 2'd2);
  assign act_top = buf_idx ? top1 : top0;
  assign act_bot = buf_idx ? bot1 : bot0;

  pal_fetch #(
    .ADDR_W (ADDR_W),
    .DEPTH  (PAL_DEPTH),
    .W      (PAL_W)
  ) u_fetch (
    .clk       (clk),
    .rst       (rst),
    .start     (fetch_start),
    .abort     (!enable),
    .base      (fetch_base),
    .rd_req    (rd_req),
    .rd_addr   (rd_addr),
    .rd_ready  (rd_ready),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .we        (pr_we),
    .waddr     (pr_waddr),
    .wdata     (pr_wdata),
    .hdr       (hdr),
    .done      (fetch_done)
  );

  pal_ram #(
    .DEPTH (PAL_DEPTH),
    .W     (PAL_W)
  ) u_ram (
    .clk   (clk),
    .we    (pr_we),
    .waddr (pr_waddr),
    .wdata (pr_wdata),
    .raddr (pal_raddr),
    .rdata (pal_rdata)
  );

  frame_geom #(
    .ADDR_W     (ADDR_W),
    .DIM_W      (DIM_W),
    .LONG_SKIP  (PAL_BYTES),
    .SHORT_SKIP (SHORT_SKIP)
  ) u_geom (
    .clk       (clk),
    .rst       (rst),
    .calc      (calc),
    .code      (hdr[DEPTH_LSB +: 3]),
    .use_pal   (use_pal),
    .width_m1  (width_m1),
    .height_m1 (height_m1),
    .sub_on    (sub_on),
    .sub_first (sub_first),
    .sub_line  (sub_line),
    .top       (act_top),
    .bot       (act_bot),
    .g_bpp     (g_bpp),
    .g_base    (g_base),
    .g_stride  (g_stride),
    .g_first   (g_first),
    .g_count   (g_count),
    .g_over    (g_over),
    .g_unsup   (g_unsup)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_OFF;
      buf_idx     <= 1'b0;
      for_frame   <= 1'b0;
      fetch_start <= 1'b0;
      fetch_base  <= '0;
      calc        <= 1'b0;
      frame_go    <= 1'b0;
      cur_buf     <= 1'b0;
      pix_base    <= '0;
      pix_bpp     <= '0;
      line_stride <= '0;
      first_line  <= '0;
      line_count  <= '0;
      dma_cond    <= '0;
      dma_err_irq <= 1'b0;
      sync_error  <= 1'b0;
      disable_req <= 1'b0;
      pal_loaded  <= 1'b0;
    end else begin
      fetch_start <= 1'b0;
      calc        <= 1'b0;
      frame_go    <= 1'b0;
      dma_err_irq <= 1'b0;
      disable_req <= 1'b0;
      if (!enable) begin
        state <= ST_OFF;
      end else begin
        case (state)
          ST_OFF: begin
            sync_error <= 1'b0;
            pal_loaded <= 1'b0;
            dma_cond   <= '0;
            buf_idx    <= 1'b0;
            state      <= ST_CHECK;
          end
          ST_CHECK: begin
            if (!bufs_valid) begin
              dma_cond[2] <= 1'b1;
              dma_err_irq <= dma_err_ie;
              disable_req <= 1'b1;
              state       <= ST_HALT;
            end else if (use_pal) begin
              fetch_start <= 1'b1;
              fetch_base  <= act_top;
              for_frame   <= 1'b0;
              state       <= ST_FETCH;
            end else begin
              state <= ST_IDLE;
            end
          end
          ST_FETCH: begin
            if (fetch_done) begin
              pal_loaded <= 1'b1;
              if (for_frame) begin
                calc  <= 1'b1;
                state <= ST_EVAL;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_IDLE: begin
            if (frame_tick && load_mode != 2'd1) begin
              if (use_pal) begin
                fetch_start <= 1'b1;
                fetch_base  <= act_top;
                for_frame   <= 1'b1;
                state       <= ST_FETCH;
              end else begin
                calc  <= 1'b1;
                state <= ST_EVAL;
              end
            end
          end
          ST_EVAL: state <= ST_DECIDE;
          ST_DECIDE: begin
            if (g_unsup) begin
              state <= ST_IDLE;
            end else if (g_over) begin
              sync_error  <= 1'b1;
              disable_req <= 1'b1;
              state       <= ST_HALT;
            end else begin
              frame_go          <= 1'b1;
              cur_buf           <= buf_idx;
              pix_base          <= g_base;
              pix_bpp           <= g_bpp;
              line_stride       <= g_stride;
              first_line        <= g_first;
              line_count        <= g_count;
              dma_cond[buf_idx] <= 1'b1;
              if (dual_buf) buf_idx <= ~buf_idx;
              state <= ST_IDLE;
            end
          end
          default: state <= ST_HALT;
        endcase
      end
    end
  end

endmodule

// File: rtl/frame_seq_chk.sv
module frame_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int DIM_W  = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              enable,
  input logic [1:0]        load_mode,
  input logic              dual_buf,
  input logic              rd_req,
  input logic              rd_ready,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              frame_go,
  input logic              disable_req,
  input logic              sync_error,
  input logic [2:0]        dma_cond,
  input logic [4:0]        pix_bpp,
  input logic [ADDR_W-1:0] pix_base,
  input logic              cur_buf,
  input logic [ADDR_W-1:0] top0,
  input logic [ADDR_W-1:0] top1
);

  // R11: a pending request holds until accepted
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
    rd_req && !rd_ready |=> rd_req && $stable(rd_addr));

  // R2: a drawn frame always carries a legal depth
  assert_legal_depth_R2: assert property (@(posedge clk) disable iff (rst)
    frame_go |-> (pix_bpp == 5'd2 || pix_bpp == 5'd4 ||
                  pix_bpp == 5'd8 || pix_bpp == 5'd16));

  // R4: a stopped frame is never also started
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    !(frame_go && disable_req));

  // R6: a stop request always has a recorded cause
  assert_stop_cause_R6: assert property (@(posedge clk) disable iff (rst)
    disable_req |-> (sync_error || dma_cond[2]));

  // R10: nothing happens while disabled
  assert_quiet_off_R10: assert property (@(posedge clk) disable iff (rst)
    (!enable && !$past(enable)) |-> (!rd_req && !frame_go));

  // R3: pixel data never starts before the buffer top
  assert_base_in_buf_R3: assert property (@(posedge clk) disable iff (rst)
    frame_go |-> pix_base >= (cur_buf ? top1 : top0));

  // R5: single-buffer mode stays on buffer 0
  assert_single_buf_R5: assert property (@(posedge clk) disable iff (rst)
    frame_go && !dual_buf |-> !cur_buf);

  // R1: no palette read is issued in draw-only mode
  assert_no_read_mode2_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_req) |-> load_mode != 2'd2);

endmodule

bind frame_seq frame_seq_chk #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_chk (.*);

// File: tb/frame_seq_test.sv
`timescale 1ns/1ps
module frame_seq_test;

  localparam int AW = 32;
  localparam int DW = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          enable = 1'b0;
  logic [1:0]    load_mode = 2'd0;
  logic          dual_buf = 1'b0;
  logic          dma_err_ie = 1'b0;
  logic          bufs_valid = 1'b1;
  logic [DW-1:0] width_m1 = '0, height_m1 = '0, sub_line = '0;
  logic          sub_on = 1'b0, sub_first = 1'b0;
  logic [AW-1:0] top0 = 32'h0010_0000, bot0 = 32'h0011_0000;
  logic [AW-1:0] top1 = 32'h0020_0000, bot1 = 32'h0021_0000;
  logic          frame_tick = 1'b0;
  logic          rd_req;
  logic [AW-1:0] rd_addr;
  logic          rd_ready = 1'b0;
  logic          rsp_valid = 1'b0;
  logic [15:0]   rsp_data = '0;
  logic [7:0]    pal_raddr = '0;
  logic [15:0]   pal_rdata;
  logic          frame_go, cur_buf, dma_err_irq, sync_error, disable_req, pal_loaded;
  logic [AW-1:0] pix_base;
  logic [4:0]    pix_bpp;
  logic [DW+2:0] line_stride;
  logic [DW-1:0] first_line;
  logic [DW:0]   line_count;
  logic [2:0]    dma_cond;

  frame_seq uut (
    .clk(clk), .rst(rst), .enable(enable), .load_mode(load_mode),
    .dual_buf(dual_buf), .dma_err_ie(dma_err_ie), .bufs_valid(bufs_valid),
    .width_m1(width_m1), .height_m1(height_m1), .sub_on(sub_on),
    .sub_first(sub_first), .sub_line(sub_line), .top0(top0), .bot0(bot0),
    .top1(top1), .bot1(bot1), .frame_tick(frame_tick), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_ready(rd_ready), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .pal_raddr(pal_raddr), .pal_rdata(pal_rdata),
    .frame_go(frame_go), .cur_buf(cur_buf), .pix_base(pix_base),
    .pix_bpp(pix_bpp), .line_stride(line_stride), .first_line(first_line),
    .line_count(line_count), .dma_cond(dma_cond), .dma_err_irq(dma_err_irq),
    .sync_error(sync_error), .disable_req(disable_req), .pal_loaded(pal_loaded)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0, cycles = 0;
  int cnt_go = 0, cnt_dis = 0, cnt_irq = 0, n_reads = 0;
  logic [15:0] hdr0 = 16'h3000, hdr1 = 16'h1000;
  logic          pend = 1'b0;
  logic [AW-1:0] pend_addr = '0;
  logic          s_buf;
  logic [AW-1:0] s_base;
  logic [4:0]    s_bpp;
  logic [DW+2:0] s_stride;
  logic [DW-1:0] s_first;
  logic [DW:0]   s_count;

  function automatic logic [15:0] mem_word(input logic [AW-1:0] a);
    if (a == top0) return hdr0;
    if (a == top1) return hdr1;
    return a[16:1] ^ 16'h3C5A;
  endfunction

  function automatic int e_bpp(input int code);
    case (code)
      0: return 0;
      1: return 2;
      2: return 4;
      3: return 8;
      default: return 16;
    endcase
  endfunction

  function automatic longint e_skip(input int code, input int mode);
    if (mode == 2) return 0;
    return (code >= 3) ? 512 : 32;
  endfunction

  function automatic bit e_over(input int code, input int mode, input longint w,
                                input longint h, input longint t, input longint b);
    longint need;
    need = e_skip(code, mode) + (w * h * e_bpp(code)) / 8;
    return need > (b - t) + 2;
  endfunction

  // memory model: random ready, data one clock after acceptance
  always @(negedge clk) begin
    rsp_valid <= pend;
    rsp_data  <= mem_word(pend_addr);
    rd_ready  <= ($urandom % 4) != 0;
  end
  always @(negedge clk) begin
    #0.5;
    pend      = rd_req && rd_ready;
    pend_addr = rd_addr;
  end

  // event monitor, settled after each rising edge
  always begin
    @(posedge clk);
    #1;
    cycles++;
    if (pend) n_reads++;
    if (disable_req) cnt_dis++;
    if (dma_err_irq) cnt_irq++;
    if (frame_go) begin
      cnt_go++;
      s_buf = cur_buf; s_base = pix_base; s_bpp = pix_bpp;
      s_stride = line_stride; s_first = first_line; s_count = line_count;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic enable_on();
    int d0;
    d0 = cnt_dis;
    @(negedge clk) enable = 1'b1;
    if (load_mode == 2'd2) begin
      repeat (8) @(negedge clk);
    end else begin
      for (int i = 0; i < 2000; i++) begin
        @(negedge clk);
        if (pal_loaded || cnt_dis != d0) break;
      end
    end
  endtask

  task automatic enable_off();
    @(negedge clk) enable = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic frame(output bit got_go, output bit got_dis);
    int g0, d0;
    g0 = cnt_go; d0 = cnt_dis;
    @(negedge clk) frame_tick = 1'b1;
    @(negedge clk) frame_tick = 1'b0;
    for (int i = 0; i < 1500; i++) begin
      if (cnt_go != g0 || cnt_dis != d0) break;
      @(negedge clk);
    end
    @(negedge clk);
    got_go  = (cnt_go != g0);
    got_dis = (cnt_dis != d0);
  endtask

  task automatic pal_peek(input int idx, output logic [15:0] d);
    @(negedge clk) pal_raddr = 8'(idx);
    @(negedge clk) d = pal_rdata;
  endtask

  initial begin
    while (cycles < 190000) @(negedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit go, dis;
    int r0;
    logic [15:0] pw;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12: reset state
    chk("R12 rd_req", rd_req, 0);
    chk("R12 sync_error", sync_error, 0);
    chk("R12 dma_cond", dma_cond, 0);
    chk("R12 pal_loaded", pal_loaded, 0);

    // R10: ticks with enable low do nothing
    r0 = n_reads;
    frame(go, dis);
    chk("R10 no frame while off", go, 0);
    chk("R10 no reads while off", n_reads - r0, 0);

    // basic frame, depth code 3
    width_m1 = 10'd15; height_m1 = 10'd7; hdr0 = 16'h3000;
    r0 = n_reads;
    enable_on();
    chk("R9 pal_loaded at enable", pal_loaded, 1);
    chk("R1 initial fetch words", n_reads - r0, 256);
    r0 = n_reads;
    frame(go, dis);
    chk("R1 per-frame fetch words", n_reads - r0, 256);
    chk("R2 frame drawn", go, 1);
    chk("R2 bpp code 3", s_bpp, 8);
    chk("R3 base long skip", s_base, top0 + 512);
    chk("R8 stride", s_stride, 16);
    chk("R7 count no subpanel", s_count, 8);
    chk("R7 first no subpanel", s_first, 0);
    chk("R5 cond buf0", dma_cond, 3'b001);
    pal_peek(0, pw);   chk("R1 palette entry 0", pw, 16'h3000);
    pal_peek(1, pw);   chk("R1 palette entry 1", pw, mem_word(top0 + 2));
    pal_peek(255, pw); chk("R1 palette entry 255", pw, mem_word(top0 + 510));
    frame(go, dis);
    chk("R5 single buffer stays 0", s_buf, 0);
    enable_off();

    // R5 dual buffers, second buffer header code 1
    dual_buf = 1'b1; hdr1 = 16'h1000;
    enable_on();
    frame(go, dis);
    chk("R5 dual first buf", s_buf, 0);
    frame(go, dis);
    chk("R5 dual second buf", s_buf, 1);
    chk("R2 bpp code 1", s_bpp, 2);
    chk("R3 base short skip", s_base, top1 + 32);
    chk("R5 cond both", dma_cond, 3'b011);
    pal_peek(1, pw);   chk("R1 palette from buf1", pw, mem_word(top1 + 2));
    frame(go, dis);
    chk("R5 dual wraps", s_buf, 0);
    enable_off();
    dual_buf = 1'b0;

    // R2 unsupported code 0
    hdr0 = 16'h0000;
    enable_on();
    frame(go, dis);
    chk("R2 code 0 no frame", go, 0);
    chk("R2 code 0 cond untouched", dma_cond, 0);
    enable_off();

    // R4 overflow boundary: code 4, 8x4 -> 64 bytes + 512 = 576
    hdr0 = 16'h4000; width_m1 = 10'd7; height_m1 = 10'd3;
    bot0 = top0 + 574;
    enable_on();
    frame(go, dis);
    chk("R4 exact fit draws", go, 1);
    chk("R2 bpp code 4", s_bpp, 16);
    enable_off();
    bot0 = top0 + 573;
    enable_on();
    frame(go, dis);
    chk("R4 overflow no frame", go, 0);
    chk("R4 overflow stop", dis, 1);
    chk("R4 sync_error", sync_error, 1);
    frame(go, dis);
    chk("R4 halted ignores tick", go, 0);
    enable_off();
    bot0 = top0 + 32'h1_0000;
    enable_on();
    chk("R12 sync_error cleared", sync_error, 0);
    enable_off();

    // R6 invalid buffer addresses
    bufs_valid = 1'b0; dma_err_ie = 1'b1;
    r0 = n_reads; pw = 16'(cnt_irq);
    enable_on();
    chk("R6 no reads", n_reads - r0, 0);
    chk("R6 cond bit2", dma_cond, 3'b100);
    chk("R6 irq pulse", cnt_irq - int'(pw), 1);
    enable_off();
    dma_err_ie = 1'b0; pw = 16'(cnt_irq);
    enable_on();
    chk("R6 irq masked", cnt_irq - int'(pw), 0);
    enable_off();
    bufs_valid = 1'b1;

    // R10 palette-only mode
    load_mode = 2'd1; hdr0 = 16'h3000;
    enable_on();
    chk("R10 mode1 palette loaded", pal_loaded, 1);
    frame(go, dis);
    chk("R10 mode1 no frame", go, 0);
    enable_off();

    // R3/R9 draw-only mode reuses the held header (code 3)
    load_mode = 2'd2; r0 = n_reads;
    enable_on();
    frame(go, dis);
    chk("R9 mode2 no pal_loaded", pal_loaded, 0);
    chk("R1 mode2 no reads", n_reads - r0, 0);
    chk("R3 mode2 zero skip", s_base, top0);
    chk("R2 mode2 held depth", s_bpp, 8);
    enable_off();
    load_mode = 2'd0;

    // R7 subpanel
    sub_on = 1'b1; sub_first = 1'b1; sub_line = 10'd5;
    enable_on();
    frame(go, dis);
    chk("R7 first line", s_first, 5);
    chk("R7 count full", s_count, 4);
    enable_off();
    sub_first = 1'b0;
    enable_on();
    frame(go, dis);
    chk("R7 count replaced", s_count, 5);
    chk("R7 first zero", s_first, 0);
    enable_off();
    sub_on = 1'b0;

    // random geometry and bounds around the limit
    for (int it = 0; it < 14; it++) begin
      int code, w, h, dlt;
      longint need;
      bit ov;
      code = 1 + ($urandom % 7);
      w = 1 + ($urandom % 64);
      h = 1 + ($urandom % 64);
      dlt = int'($urandom % 6) - 3;
      hdr0 = 16'(code << 12) | 16'($urandom % 4096);
      width_m1 = DW'(w - 1); height_m1 = DW'(h - 1);
      need = e_skip(code, 0) + (longint'(w) * h * e_bpp(code)) / 8;
      bot0 = top0 + AW'(need - 2 + dlt);
      ov = e_over(code, 0, w, h, top0, bot0);
      enable_on();
      frame(go, dis);
      chk("R4 random overflow", dis, ov);
      chk("R4 random draw", go, !ov);
      if (!ov) begin
        chk("R2 random bpp", s_bpp, e_bpp(code));
        chk("R3 random base", s_base, top0 + AW'(e_skip(code, 0)));
        chk("R8 random stride", s_stride, (w * e_bpp(code)) / 8);
      end
      enable_off();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule